// File: doc/BRIEF.md
# Main oscillator frequency verifier

This block watches a main oscillator from the standpoint of a trusted reference clock. It counts the rising edges of the watched clock over a fixed window of reference cycles. At the end of each window it compares the count against a programmable floor and ceiling. A count above the ceiling marks the oscillator as running too fast. A count below the floor marks it as too slow, and a clock that has stopped gives a count of zero and so lands in the too-slow case.

Checking runs only while the enable input is high. A failure sets a sticky cause flag. If the reset-on-failure option is set, the block also issues a one-cycle request for a power-on-class reset and keeps the interrupt request low until that reset arrives. The cause flags are not cleared by the ordinary system reset, so the code that runs after the reset sees them with the non-maskable interrupt request raised. If the reset option is off, the interrupt request is raised straight away. Software clears the flags by pulsing a write-one-to-clear input, and a cold power-up reset also clears them.

The watched clock must run below half the reference rate for the count to be exact.

Top module: `osc_verify`

## Requirements
- R1: When the number of watched-clock rising edges in a window exceeds `hi_bound`, `err_fast` is set.
- R2: When the number of edges in a window is below `lo_bound`, `err_slow` is set.
- R3: Both bounds are inclusive: a count equal to `lo_bound` or to `hi_bound` sets no flag.
- R4: A watched clock that is stopped for a whole window gives a count of zero and sets `err_slow`.
- R5: While `chk_en` is low, no counting takes place and neither error flag is set. Raising `chk_en` starts a fresh window.
- R6: A window ends on the WIN_CYCLES-th rising reference edge after `chk_en` rises. Flags are updated at that edge, not before, and counting restarts.
- R7: With `rst_on_fail` high, a failure drives `reset_req` high for exactly one cycle, and `nmi_req` stays low until `rst_n` has been asserted.
- R8: `err_fast` and `err_slow` keep their values through `rst_n`, and `nmi_req` is high after that reset. Only `cold_rst_n` or a clear removes them.
- R9: With `rst_on_fail` low, `nmi_req` rises at the window edge that sets a flag, and `reset_req` stays low.
- R10: A high `cause_clr` at a rising edge clears both flags and `nmi_req`. If a window fails at the same edge, the new failure wins.
- R11: After `cold_rst_n` and `rst_n`, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trusted reference clock |
| cold_rst_n | input | 1 | Power-up reset, active low, synchronous; clears everything |
| rst_n | input | 1 | System reset, active low, synchronous; cause flags survive it |
| mon_clk | input | 1 | Oscillator being verified |
| chk_en | input | 1 | Verification enable |
| rst_on_fail | input | 1 | Request a reset on failure instead of raising the NMI at once |
| lo_bound | input | CNT_W | Smallest acceptable edge count per window |
| hi_bound | input | CNT_W | Largest acceptable edge count per window |
| cause_clr | input | 1 | Write-one-to-clear strobe for the cause flags |
| err_fast | output | 1 | Sticky flag: oscillator too fast |
| err_slow | output | 1 | Sticky flag: oscillator too slow or stopped |
| reset_req | output | 1 | One-cycle power-on-class reset request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
A software clear and a window-end failure can fall on the same reference edge. To provoke this, the bench enables checking with a fast oscillator and counts exactly WIN_CYCLES-1 edges, which leaves no flag set. It then holds `cause_clr` high for the WIN_CYCLES-th edge. The collision is judged correct when the flag is still low before that edge and high after it, showing that the evaluation lands on the expected cycle and that the set overrides the clear.

// File: rtl/ov_pkg.sv
`timescale 1ns/1ps
// Shared types and the bound comparison for the oscillator verifier.
// Assumes counts no wider than 32 bits.
package ov_pkg;

    typedef struct packed {
        logic fast;
        logic slow;
    } ov_verdict_t;

    // Classify one window count against inclusive bounds.
    function automatic ov_verdict_t ov_judge(input logic [31:0] cnt,
                                             input logic [31:0] lo,
                                             input logic [31:0] hi);
        ov_verdict_t v;
        v.fast = (cnt > hi);
        v.slow = (cnt < lo);
        return v;
    endfunction

endpackage

// File: rtl/ov_toggle_sync.sv
`timescale 1ns/1ps
// Carries watched-clock edges into the reference domain. A flop in the
// watched domain toggles on every rising edge. The reference domain
// synchronises it through SYNC_STAGES flops and emits a one-cycle pulse
// for every change it sees.
// Assumes the watched clock runs below half the reference rate.
module ov_toggle_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic edge_pulse
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic             tgl;
    logic [CHAIN-1:0] chain;

    // Watched domain: flip once per rising edge.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) tgl <= 1'b0;
        else        tgl <= ~tgl;
    end

    // Reference domain: shift the toggle through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN-2:0], tgl};
    end

    // A change between the last two stages marks one watched edge.
    always_comb edge_pulse = chain[CHAIN-1] ^ chain[CHAIN-2];

endmodule

// File: rtl/ov_window_count.sv
`timescale 1ns/1ps
// Counts edge pulses over windows of WIN_CYCLES reference cycles.
// 'done' is high in the last cycle of a window. In that cycle 'total'
// holds the full count, including that cycle's pulse. The count
// saturates at its maximum. Dropping 'run' clears both counters.
module ov_window_count #(
    parameter int WIN_CYCLES = 256,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             edge_pulse,
    output logic             done,
    output logic [CNT_W-1:0] total
);
    localparam int               WIN_W   = $clog2(WIN_CYCLES);
    localparam logic [WIN_W-1:0] LAST    = WIN_W'(WIN_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] edge_cnt;

    // Window end and saturating running total.
    always_comb begin
        done  = run && (win_cnt == LAST);
        total = (edge_cnt == CNT_MAX) ? CNT_MAX : edge_cnt + CNT_W'(edge_pulse);
    end

    // Position within the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) win_cnt <= '0;
        else if (done)      win_cnt <= '0;
        else                win_cnt <= win_cnt + WIN_W'(1);
    end

    // Edges gathered so far in this window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) edge_cnt <= '0;
        else if (done)      edge_cnt <= '0;
        else                edge_cnt <= total;
    end

    // Windows are at least two cycles long, so two ends never meet.
    assert_window_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Inside a window the count never wraps downward.
    assert_count_no_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (edge_cnt >= $past(edge_cnt)));

endmodule

// File: rtl/ov_fault_ctrl.sv
`timescale 1ns/1ps
// Holds the sticky cause flags and decides between a reset request and an
// immediate NMI. The flags reset only on cold_rst_n. The pending-reset
// marker that holds back the NMI clears on the system reset.
// Assumes 'done' comes from logic that is held idle during rst_n.
module ov_fault_ctrl
    import ov_pkg::*;
(
    input  logic        clk,
    input  logic        cold_rst_n,
    input  logic        rst_n,
    input  logic        done,
    input  ov_verdict_t verdict,
    input  logic        rst_on_fail,
    input  logic        cause_clr,
    output logic        err_fast,
    output logic        err_slow,
    output logic        reset_req,
    output logic        nmi_req
);
    logic hit;
    logic fail;
    logic await_rst;

    // Qualify the window verdict.
    always_comb begin
        hit  = done && rst_n;
        fail = hit && (verdict.fast || verdict.slow);
    end

    // Sticky causes: a new failure wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            err_fast <= 1'b0;
            err_slow <= 1'b0;
        end else begin
            err_fast <= (err_fast && !cause_clr) || (hit && verdict.fast);
            err_slow <= (err_slow && !cause_clr) || (hit && verdict.slow);
        end
    end

    // One-cycle reset request on a failure when the option is set.
    always_ff @(posedge clk) begin
        if (!rst_n || !cold_rst_n) reset_req <= 1'b0;
        else                       reset_req <= fail && rst_on_fail;
    end

    // Hold back the NMI until the requested reset has happened.
    always_ff @(posedge clk) begin
        if (!rst_n || !cold_rst_n) await_rst <= 1'b0;
        else                       await_rst <= (await_rst && !cause_clr) || (fail && rst_on_fail);
    end

    // Raise the NMI while a cause is recorded and no reset is pending.
    always_comb nmi_req = (err_fast || err_slow) && !await_rst;

    assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        reset_req |=> !reset_req);

    assert_req_needs_option_R7: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        reset_req |-> $past(rst_on_fail));

    assert_nmi_held_R7: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        reset_req |-> !nmi_req);

    assert_cause_survives_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!rst_n && !cause_clr) |=> ($stable(err_fast) && $stable(err_slow)));

    assert_set_on_window_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        ($rose(err_fast) || $rose(err_slow)) |-> $past(done));

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (cause_clr && !hit) |=> (!err_fast && !err_slow && !nmi_req));

endmodule

// File: rtl/osc_verify.sv
`timescale 1ns/1ps
// Main oscillator frequency verifier. Counts watched-clock edges over a
// reference window and flags over-speed and under-speed. On failure it
// either requests a reset or raises an NMI, and the sticky causes
// survive that reset.
// Assumes clk is trusted, mon_clk is below clk/2, and CNT_W <= 32.
module osc_verify
    import ov_pkg::*;
#(
    parameter int WIN_CYCLES  = 256,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             cold_rst_n,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic             chk_en,
    input  logic             rst_on_fail,
    input  logic [CNT_W-1:0] lo_bound,
    input  logic [CNT_W-1:0] hi_bound,
    input  logic             cause_clr,
    output logic             err_fast,
    output logic             err_slow,
    output logic             reset_req,
    output logic             nmi_req
);
    logic             sys_rst_n;
    logic             edge_pulse;
    logic             win_done;
    logic [CNT_W-1:0] win_total;
    ov_verdict_t      verdict;

    // Either reset idles the measuring path.
    always_comb sys_rst_n = rst_n && cold_rst_n;

    // Verdict for the count that is closing now.
    always_comb verdict = ov_judge(32'(win_total), 32'(lo_bound), 32'(hi_bound));

    ov_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .mon_clk    (mon_clk),
        .edge_pulse (edge_pulse)
    );

    ov_window_count #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .run        (chk_en),
        .edge_pulse (edge_pulse),
        .done       (win_done),
        .total      (win_total)
    );

    ov_fault_ctrl u_ctrl (
        .clk         (clk),
        .cold_rst_n  (cold_rst_n),
        .rst_n       (rst_n),
        .done        (win_done),
        .verdict     (verdict),
        .rst_on_fail (rst_on_fail),
        .cause_clr   (cause_clr),
        .err_fast    (err_fast),
        .err_slow    (err_slow),
        .reset_req   (reset_req),
        .nmi_req     (nmi_req)
    );

    // With checking off, no flag can rise at the next edge.
    assert_idle_no_flag_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !chk_en |=> !($rose(err_fast) || $rose(err_slow)));

endmodule

// File: tb/sim_osc_verify.sv
`timescale 1ns/1ps
module sim_osc_verify;
    localparam int W = 16;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         mon_clk = 1'b0;
    logic         cold_rst_n, rst_n, chk_en, rst_on_fail, cause_clr;
    logic [W-1:0] lo_bound, hi_bound;
    logic         err_fast, err_slow, reset_req, nmi_req;
    int           mon_h = 16;
    int           checks = 0;
    int           failures = 0;
    int           rr_seen = 0;

    // Vector table: watched half-period (ns), bounds, expected fast/slow.
    // Over 512 ns: h=16 gives 16 edges, h=8 gives 32, h=32 gives 8.
    localparam int V_H   [6] = '{16, 8, 32, 16, 16, 16};
    localparam int V_LO  [6] = '{14, 14, 14, 16, 17, 10};
    localparam int V_HI  [6] = '{18, 18, 18, 16, 20, 15};
    localparam int V_FST [6] = '{0, 1, 0, 0, 0, 1};
    localparam int V_SLW [6] = '{0, 0, 1, 0, 1, 0};

    osc_verify #(.WIN_CYCLES(N), .CNT_W(W)) u0 (
        .clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n), .mon_clk(mon_clk),
        .chk_en(chk_en), .rst_on_fail(rst_on_fail), .lo_bound(lo_bound),
        .hi_bound(hi_bound), .cause_clr(cause_clr), .err_fast(err_fast),
        .err_slow(err_slow), .reset_req(reset_req), .nmi_req(nmi_req));

    always #4 clk = ~clk;

    // Watched clock: edges fall 1 ns past a multiple of 8 ns; mon_h of 0 stops it.
    initial begin
        #1;
        forever begin
            if (mon_h == 0) #8;
            else begin #(mon_h) mon_clk = ~mon_clk; end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_watch(input int n);
        repeat (n) begin
            @(negedge clk);
            if (reset_req) rr_seen++;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        cold_rst_n = 0; rst_n = 0; chk_en = 0; rst_on_fail = 0; cause_clr = 0;
        lo_bound = '0; hi_bound = '0;
        tick(4);
        cold_rst_n = 1; rst_n = 1;
        tick(1);
        chk("R11 err_fast", int'(err_fast), 0);
        chk("R11 err_slow", int'(err_slow), 0);
        chk("R11 nmi_req", int'(nmi_req), 0);
        chk("R11 reset_req", int'(reset_req), 0);

        // Table walk: R1, R2, R3, R9, R10.
        for (int i = 0; i < 6; i++) begin
            chk_en = 0; mon_h = V_H[i];
            lo_bound = W'(V_LO[i]); hi_bound = W'(V_HI[i]);
            tick(20);
            rr_seen = 0;
            chk_en = 1;
            tick_watch(70);
            chk($sformatf("R1 vec%0d err_fast", i), int'(err_fast), V_FST[i]);
            chk($sformatf("R2_R3 vec%0d err_slow", i), int'(err_slow), V_SLW[i]);
            chk($sformatf("R9 vec%0d nmi_req", i), int'(nmi_req), V_FST[i] | V_SLW[i]);
            chk($sformatf("R9 vec%0d reset pulses", i), rr_seen, 0);
            chk_en = 0; cause_clr = 1;
            tick(1);
            cause_clr = 0;
            chk($sformatf("R10 vec%0d flags cleared", i), int'(err_fast | err_slow), 0);
            chk($sformatf("R10 vec%0d nmi cleared", i), int'(nmi_req), 0);
        end

        // R5: disabled with a failing setup for several window lengths.
        mon_h = 8; lo_bound = 14; hi_bound = 18; chk_en = 0;
        tick(200);
        chk("R5 no flag while disabled", int'(err_fast | err_slow), 0);
        chk("R5 no nmi while disabled", int'(nmi_req), 0);

        // R4: stopped clock.
        mon_h = 0;
        tick(20);
        chk_en = 1;
        tick(70);
        chk("R4 stopped err_slow", int'(err_slow), 1);
        chk("R4 stopped err_fast", int'(err_fast), 0);
        chk_en = 0; cause_clr = 1; tick(1); cause_clr = 0;
        mon_h = 16;
        tick(20);

        // R6 and R10: evaluation edge and a clear at the same edge.
        mon_h = 8;
        tick(20);
        chk_en = 1;
        tick(N - 1);
        chk("R6 no flag before window end", int'(err_fast), 0);
        cause_clr = 1;
        tick(1);
        cause_clr = 0;
        chk("R6_R10 set wins over clear", int'(err_fast), 1);
        chk_en = 0; cause_clr = 1; tick(1); cause_clr = 0;
        chk("R10 plain clear", int'(err_fast), 0);

        // R7 and R8: reset on failure, then causes survive the reset.
        rst_on_fail = 1; rr_seen = 0;
        tick(20);
        chk_en = 1;
        tick_watch(70);
        chk("R7 one reset pulse", rr_seen, 1);
        chk("R7 err_fast set", int'(err_fast), 1);
        chk("R7 nmi held back", int'(nmi_req), 0);
        chk_en = 0; rst_on_fail = 0;
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(1);
        chk("R8 err_fast survives", int'(err_fast), 1);
        chk("R8 nmi after reset", int'(nmi_req), 1);
        chk("R8 reset_req low", int'(reset_req), 0);
        cold_rst_n = 0;
        tick(2);
        cold_rst_n = 1;
        tick(1);
        chk("R8_R11 cold clears err_fast", int'(err_fast), 0);
        chk("R8_R11 cold clears nmi", int'(nmi_req), 0);

        summary();
        $finish;
    end
endmodule